// File: doc/BRIEF.md
# Battery Check Sequencer for a Serial Converter

This block is a host-side master for a three-wire serial analog-to-digital converter that has an internal voltage reference and a monitoring channel scaled from the supply. A single pulse on `go` runs a fixed script. The script first writes the converter's control bits so that the internal reference is switched on. It then sets the monitoring channel (channel 7) to analog mode and reads that channel until it can reach a verdict. Last, it sets channel 7 back to digital mode so that its input divider draws no current.

The verdict is debounced. Any reading of 128 or more ends the check at once with a battery-ok result. A run of `LOW_RUN` readings below 128 in a row gives a battery-low result. The serial clock is derived from the system clock. Its half period is the `clk_div` setting, but never less than the floor `MIN_HALF`, which keeps the line within the converter's maximum interface rate.

Top module: `bchk_top`

## Requirements
- R1: After reset, START is high, CLK is low, DIO is released (`dio_oe` low), `busy` is low, and both results are low.
- R2: A `go` pulse while idle raises `busy` in the next cycle and clears both results. A `go` pulse while `busy` is high has no effect on the script or on the frames sent.
- R3: Every high phase and every low phase of CLK lasts exactly max(`clk_div`, `MIN_HALF`) system cycles. `clk_div` is captured when the check starts.
- R4: CLK toggles only while START is low. START falls at least one half period before the first CLK rise. DIO and its enable change only while CLK is low, most significant bit first. START stays high for at least one full CLK period between frames.
- R5: The control frame is 7 bits: command 0,1,1 followed by pull-up 0, pull-down 1, reference-on 1, test bit 0.
- R6: An attribute frame is 11 bits: command 0,0,1 followed by one bit per channel from channel 7 down to channel 0, where 1 means analog. In the first attribute frame channel 7 is 1, and channel i (i < 7) takes `chan_cfg[i]`.
- R7: A read frame drives 1,0,0,1,1,1 (command and channel 7) and then releases DIO. It gives `TURN_CLKS` further clocks and then 8 more clocks, sampling `dio_in` on each of those 8 rising CLK edges, MSB first. The frame has 6+`TURN_CLKS`+8 clocks in total.
- R8: A reading whose MSB is 1 (a value of 128 or more) ends the reading phase with `batt_ok`, and no further read is sent.
- R9: `LOW_RUN` consecutive readings below 128 end the reading phase with `batt_low`.
- R10: The count of consecutive low readings starts from zero at every check.
- R11: After the verdict, a last attribute frame sets channel 7 to 0 and leaves channels 0 to 6 as in R6. When this frame ends, `busy` falls and exactly one result goes high. The results hold until the next accepted `go`.
- R12: The frames are sent in this order: control, attribute, one or more reads, attribute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Single-cycle request to run a check |
| clk_div | input | DIV_W | Requested CLK half period in system cycles |
| chan_cfg | input | 7 | Analog(1)/digital(0) setting for channels 0..6 |
| dio_in | input | 1 | Data line as seen by the host |
| ser_start | output | 1 | Frame select line, low during a frame |
| ser_clk | output | 1 | Serial clock |
| dio_out | output | 1 | Data driven by the host |
| dio_oe | output | 1 | Host drive enable for the data line |
| busy | output | 1 | A check is in progress |
| batt_low | output | 1 | Last check found the battery low |
| batt_ok | output | 1 | Last check found the battery good |

## Verification
The bench builds the block with `MIN_HALF` = 3 and `TURN_CLKS` = 2, so that each read frame stays short. This setting also lets `clk_div` values on either side of the floor, 0 and 4 and 5, give distinct phase lengths to measure. A behavioural slave decodes every frame and answers reads from a per-check list of values. With that list the bench covers the boundary value 128, a good reading after low ones, a full run of lows, and two checks in a row that would expose a counter carried over from the earlier check.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

    localparam int NCH   = 8;
    localparam int FRM_W = 16;
    localparam int CNT_W = 6;
    localparam int RES_W = 8;

    localparam logic [2:0] OP_CTRL = 3'b011;
    localparam logic [2:0] OP_ATTR = 3'b001;
    localparam logic [2:0] OP_READ = 3'b100;
    localparam logic [2:0] MON_CH  = 3'b111;
    // pull-up off, pull-down on, reference on, test bit cleared
    localparam logic [3:0] CTRL_WORD = 4'b0110;

    typedef enum logic [1:0] {
        FK_CTRL, FK_ATTR_AN, FK_READ, FK_ATTR_DIG
    } frame_kind_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CTRL, SQ_ATTR_AN, SQ_READ, SQ_ATTR_DIG
    } seq_st_e;

    typedef enum logic [1:0] {
        FE_IDLE, FE_RUN, FE_TAIL, FE_GAP
    } fe_st_e;

    typedef enum logic [1:0] {
        V_NONE, V_OK, V_LOW
    } verdict_e;

    typedef struct packed {
        logic [FRM_W-1:0] bits;     // left-justified, first bit at MSB
        logic [CNT_W-1:0] n_out;    // bits driven by the host
        logic [CNT_W-1:0] n_total;  // CLK pulses in the frame
        logic [CNT_W-1:0] cap_from; // first pulse index that samples
    } frame_t;

    function automatic frame_t build_frame(frame_kind_e k,
                                           logic [NCH-2:0] cfg,
                                           int turn);
        frame_t f;
        f = '0;
        case (k)
            FK_CTRL: begin
                f.bits     = {OP_CTRL, CTRL_WORD, 9'b0};
                f.n_out    = CNT_W'(7);
                f.n_total  = CNT_W'(7);
                f.cap_from = CNT_W'(7);
            end
            FK_ATTR_AN: begin
                f.bits     = {OP_ATTR, 1'b1, cfg, 5'b0};
                f.n_out    = CNT_W'(3 + NCH);
                f.n_total  = CNT_W'(3 + NCH);
                f.cap_from = CNT_W'(3 + NCH);
            end
            FK_ATTR_DIG: begin
                f.bits     = {OP_ATTR, 1'b0, cfg, 5'b0};
                f.n_out    = CNT_W'(3 + NCH);
                f.n_total  = CNT_W'(3 + NCH);
                f.cap_from = CNT_W'(3 + NCH);
            end
            default: begin
                f.bits     = {OP_READ, MON_CH, 10'b0};
                f.n_out    = CNT_W'(6);
                f.n_total  = CNT_W'(6 + turn + RES_W);
                f.cap_from = CNT_W'(6 + turn);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/bchk_tick.sv
module bchk_tick #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] D_ONE = DIV_W'(1);

    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic             last;

    assign half = (div < FLOOR) ? FLOOR : div;
    assign last = (cnt == half - D_ONE);
    assign tick = run && last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + D_ONE;
        end
    end
endmodule

// File: rtl/bchk_frame.sv
module bchk_frame
    import bchk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req,
    input  frame_t           frm,
    input  logic             dio_in,
    output logic             active,
    output logic             done,
    output logic             ser_start,
    output logic             ser_clk,
    output logic             dio_out,
    output logic             dio_oe,
    output logic [RES_W-1:0] rx_data
);
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

    fe_st_e           st;
    logic [FRM_W-1:0] shreg;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] idx_nxt;
    logic [CNT_W-1:0] n_out_q;
    logic [CNT_W-1:0] n_total_q;
    logic [CNT_W-1:0] cap_q;
    logic             gap_half;

    assign active  = (st != FE_IDLE);
    assign idx_nxt = idx + C_ONE;
    assign dio_out = dio_oe & shreg[FRM_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FE_IDLE;
            shreg     <= '0;
            idx       <= '0;
            n_out_q   <= '0;
            n_total_q <= '0;
            cap_q     <= '0;
            gap_half  <= 1'b0;
            done      <= 1'b0;
            ser_start <= 1'b1;
            ser_clk   <= 1'b0;
            dio_oe    <= 1'b0;
            rx_data   <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                FE_IDLE: begin
                    if (req) begin
                        shreg     <= frm.bits;
                        n_out_q   <= frm.n_out;
                        n_total_q <= frm.n_total;
                        cap_q     <= frm.cap_from;
                        idx       <= '0;
                        rx_data   <= '0;
                        ser_start <= 1'b0;
                        ser_clk   <= 1'b0;
                        dio_oe    <= (frm.n_out != '0);
                        st        <= FE_RUN;
                    end
                end
                FE_RUN: begin
                    if (tick) begin
                        if (!ser_clk) begin
                            ser_clk <= 1'b1;
                            if (idx >= cap_q) begin
                                rx_data <= {rx_data[RES_W-2:0], dio_in};
                            end
                        end else begin
                            ser_clk <= 1'b0;
                            idx     <= idx_nxt;
                            shreg   <= {shreg[FRM_W-2:0], 1'b0};
                            dio_oe  <= (idx_nxt < n_out_q);
                            if (idx_nxt == n_total_q) begin
                                st <= FE_TAIL;
                            end
                        end
                    end
                end
                FE_TAIL: begin
                    if (tick) begin
                        ser_start <= 1'b1;
                        dio_oe    <= 1'b0;
                        gap_half  <= 1'b0;
                        st        <= FE_GAP;
                    end
                end
                default: begin
                    if (tick) begin
                        gap_half <= 1'b1;
                        if (gap_half) begin
                            done <= 1'b1;
                            st   <= FE_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bchk_seq.sv
module bchk_seq
    import bchk_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int TURN_CLKS = 2,
    parameter int LOW_RUN   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NCH-2:0]   cfg,
    input  logic [DIV_W-1:0] div,
    input  logic             done,
    input  logic [RES_W-1:0] rx_data,
    output logic             req,
    output frame_t           frm,
    output logic [DIV_W-1:0] div_q,
    output logic             busy,
    output logic             batt_low,
    output logic             batt_ok
);
    localparam int              LC_W   = $clog2(LOW_RUN + 1);
    localparam logic [LC_W-1:0] LC_MAX = LC_W'(LOW_RUN);
    localparam logic [LC_W-1:0] LC_ONE = LC_W'(1);

    seq_st_e        st;
    frame_kind_e    kind;
    verdict_e       verdict;
    logic [LC_W-1:0] low_cnt;
    logic [LC_W-1:0] low_nxt;
    logic [NCH-2:0] cfg_q;

    assign low_nxt = (low_cnt == LC_MAX) ? low_cnt : low_cnt + LC_ONE;

    always_comb begin
        case (st)
            SQ_ATTR_AN:  kind = FK_ATTR_AN;
            SQ_READ:     kind = FK_READ;
            SQ_ATTR_DIG: kind = FK_ATTR_DIG;
            default:     kind = FK_CTRL;
        endcase
    end

    assign frm = build_frame(kind, cfg_q, TURN_CLKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            req      <= 1'b0;
            verdict  <= V_NONE;
            low_cnt  <= '0;
            cfg_q    <= '0;
            div_q    <= '0;
            busy     <= 1'b0;
            batt_low <= 1'b0;
            batt_ok  <= 1'b0;
        end else begin
            req <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (go) begin
                        cfg_q    <= cfg;
                        div_q    <= div;
                        low_cnt  <= '0;
                        verdict  <= V_NONE;
                        batt_low <= 1'b0;
                        batt_ok  <= 1'b0;
                        busy     <= 1'b1;
                        req      <= 1'b1;
                        st       <= SQ_CTRL;
                    end
                end
                SQ_CTRL: begin
                    if (done) begin
                        req <= 1'b1;
                        st  <= SQ_ATTR_AN;
                    end
                end
                SQ_ATTR_AN: begin
                    if (done) begin
                        req <= 1'b1;
                        st  <= SQ_READ;
                    end
                end
                SQ_READ: begin
                    if (done) begin
                        req <= 1'b1;
                        if (rx_data[RES_W-1]) begin
                            verdict <= V_OK;
                            st      <= SQ_ATTR_DIG;
                        end else begin
                            low_cnt <= low_nxt;
                            if (low_nxt == LC_MAX) begin
                                verdict <= V_LOW;
                                st      <= SQ_ATTR_DIG;
                            end
                        end
                    end
                end
                default: begin
                    if (done) begin
                        busy     <= 1'b0;
                        batt_ok  <= (verdict == V_OK);
                        batt_low <= (verdict == V_LOW);
                        st       <= SQ_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bchk_top.sv
module bchk_top
    import bchk_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int MIN_HALF  = 8,
    parameter int TURN_CLKS = 2,
    parameter int LOW_RUN   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [NCH-2:0]   chan_cfg,
    input  logic             dio_in,
    output logic             ser_start,
    output logic             ser_clk,
    output logic             dio_out,
    output logic             dio_oe,
    output logic             busy,
    output logic             batt_low,
    output logic             batt_ok
);
    logic             tick;
    logic             active;
    logic             done;
    logic             req;
    frame_t           frm;
    logic [DIV_W-1:0] div_q;
    logic [RES_W-1:0] rx_data;

    bchk_tick #(
        .DIV_W    (DIV_W),
        .MIN_HALF (MIN_HALF)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .div  (div_q),
        .tick (tick)
    );

    bchk_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req       (req),
        .frm       (frm),
        .dio_in    (dio_in),
        .active    (active),
        .done      (done),
        .ser_start (ser_start),
        .ser_clk   (ser_clk),
        .dio_out   (dio_out),
        .dio_oe    (dio_oe),
        .rx_data   (rx_data)
    );

    bchk_seq #(
        .DIV_W     (DIV_W),
        .TURN_CLKS (TURN_CLKS),
        .LOW_RUN   (LOW_RUN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .cfg      (chan_cfg),
        .div      (clk_div),
        .done     (done),
        .rx_data  (rx_data),
        .req      (req),
        .frm      (frm),
        .div_q    (div_q),
        .busy     (busy),
        .batt_low (batt_low),
        .batt_ok  (batt_ok)
    );
endmodule

// File: rtl/bchk_sva.sv
module bchk_sva #(
    parameter int MIN_HALF = 8
) (
    input logic clk,
    input logic rst,
    input logic go,
    input logic ser_start,
    input logic ser_clk,
    input logic dio_out,
    input logic dio_oe,
    input logic busy,
    input logic batt_low,
    input logic batt_ok
);
    logic        clk_prev;
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            run_len  <= 16'd0;
        end else begin
            clk_prev <= ser_clk;
            if (ser_clk != clk_prev) begin
                run_len <= 16'd1;
            end else if (run_len != 16'hFFFF) begin
                run_len <= run_len + 16'd1;
            end
        end
    end

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ser_start && !dio_oe));

    assert_go_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (busy && !batt_low && !batt_ok));

    assert_half_len_R3: assert property (@(posedge clk) disable iff (rst)
        (ser_clk != clk_prev) |-> (run_len >= 16'(MIN_HALF)));

    assert_clk_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        ser_start |-> !ser_clk);

    assert_drive_in_frame_R4: assert property (@(posedge clk) disable iff (rst)
        dio_oe |-> !ser_start);

    assert_dio_steady_R4: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> ($stable(dio_out) && $stable(dio_oe)));

    assert_one_result_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (batt_low ^ batt_ok));

    assert_result_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go) |=> ($stable(batt_low) && $stable(batt_ok)));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(batt_low && batt_ok));
endmodule

bind bchk_top bchk_sva #(.MIN_HALF(MIN_HALF)) u_sva (.*);

// File: tb/bchk_top_test.sv
module bchk_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int MIN_HALF   = 3;
    localparam int TURN       = 2;
    localparam int RD_CLKS    = 6 + TURN + 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             go = 1'b0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [6:0]       chan_cfg = '0;
    logic             dio_in;
    logic             ser_start, ser_clk, dio_out, dio_oe;
    logic             busy, batt_low, batt_ok;

    int checks = 0;
    int errors = 0;

    bchk_top #(
        .DIV_W     (DIV_W),
        .MIN_HALF  (MIN_HALF),
        .TURN_CLKS (TURN),
        .LOW_RUN   (3)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .clk_div   (clk_div),
        .chan_cfg  (chan_cfg),
        .dio_in    (dio_in),
        .ser_start (ser_start),
        .ser_clk   (ser_clk),
        .dio_out   (dio_out),
        .dio_oe    (dio_oe),
        .busy      (busy),
        .batt_low  (batt_low),
        .batt_ok   (batt_ok)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- slave model and frame recorder ----------------
    int          cyc = 0;
    int          f_rise = 0;
    int          f_nout = 0;
    logic [15:0] f_bits = '0;
    int          f_cnt = 0;
    logic [15:0] rec_bits [0:15];
    int          rec_nout [0:15];
    int          rec_rise [0:15];
    logic [7:0]  rd_vals [0:7];
    int          rd_idx = 0;
    logic        slave_drv = 1'b0;
    int          t_sfall = 0;
    int          t_srise = -1;
    int          t_chi = 0;
    int          hi_min = 1000, hi_max = 0, lead_min = 1000, gap_min = 1000;

    assign dio_in = slave_drv;

    always @(posedge clk) cyc++;

    always @(negedge ser_start) begin
        f_rise = 0;
        f_nout = 0;
        f_bits = '0;
        t_sfall = cyc;
        if (t_srise >= 0 && (cyc - t_srise) < gap_min) gap_min = cyc - t_srise;
    end

    always @(posedge ser_start) begin
        if (f_cnt < 16) begin
            rec_bits[f_cnt] = f_bits;
            rec_nout[f_cnt] = f_nout;
            rec_rise[f_cnt] = f_rise;
        end
        f_cnt++;
        if (f_nout == 6 && f_bits[5:0] == 6'b100111 && rd_idx < 7) rd_idx++;
        t_srise = cyc;
    end

    always @(posedge ser_clk) begin
        if (f_rise == 0 && (cyc - t_sfall) < lead_min) lead_min = cyc - t_sfall;
        if (dio_oe) begin
            f_bits = {f_bits[14:0], dio_out};
            f_nout++;
        end
        f_rise++;
        t_chi = cyc;
    end

    always @(negedge ser_clk) begin
        int k;
        if ((cyc - t_chi) < hi_min) hi_min = cyc - t_chi;
        if ((cyc - t_chi) > hi_max) hi_max = cyc - t_chi;
        k = f_rise - 6 - TURN;
        if (!ser_start && f_nout == 6 && f_bits[5:0] == 6'b100111 && k >= 0 && k < 8)
            slave_drv = rd_vals[rd_idx][7 - k];
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_go();
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 40000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, "R11 busy falls", busy, 0);
    endtask

    task automatic run_check(input logic [6:0] cfg, input int div,
                             input logic [7:0] v0, input logic [7:0] v1,
                             input logic [7:0] v2,
                             input int exp_reads, input bit exp_low,
                             input string tag);
        int half;
        half = (div < MIN_HALF) ? MIN_HALF : div;
        rd_vals[0] = v0; rd_vals[1] = v1; rd_vals[2] = v2;
        for (int i = 3; i < 8; i++) rd_vals[i] = 8'hFF;
        rd_idx = 0; f_cnt = 0; t_srise = -1;
        hi_min = 1000; hi_max = 0; lead_min = 1000; gap_min = 1000;
        chan_cfg = cfg;
        clk_div = DIV_W'(div);
        pulse_go();
        chk(busy && !batt_low && !batt_ok, {"R2 go starts ", tag}, busy, 1);
        clk_div = 8'd1;  // later changes must not matter (R3 capture)
        wait_idle();
        chk(f_cnt == 3 + exp_reads, {"R12 frame count ", tag}, f_cnt, 3 + exp_reads);
        chk(rec_nout[0] == 7 && rec_rise[0] == 7 && rec_bits[0][6:0] == 7'b0110110,
            {"R5 control frame ", tag}, int'(rec_bits[0][6:0]), 7'b0110110);
        chk(rec_nout[1] == 11 && rec_bits[1][10:0] == {4'b0011, cfg},
            {"R6 attribute analog ", tag}, int'(rec_bits[1][10:0]), int'({4'b0011, cfg}));
        for (int i = 0; i < exp_reads; i++)
            chk(rec_nout[2 + i] == 6 && rec_rise[2 + i] == RD_CLKS &&
                rec_bits[2 + i][5:0] == 6'b100111,
                {"R7 read frame ", tag}, rec_rise[2 + i], RD_CLKS);
        chk(rec_nout[2 + exp_reads] == 11 &&
            rec_bits[2 + exp_reads][10:0] == {4'b0010, cfg},
            {"R11 attribute digital ", tag}, int'(rec_bits[2 + exp_reads][10:0]),
            int'({4'b0010, cfg}));
        chk(hi_min == half && hi_max == half, {"R3 high phase ", tag}, hi_min, half);
        chk(lead_min >= half, {"R4 lead before clock ", tag}, lead_min, half);
        chk(gap_min >= 2 * half, {"R4 gap between frames ", tag}, gap_min, 2 * half);
        if (exp_low)
            chk(batt_low && !batt_ok, {"R9 low verdict ", tag}, batt_low, 1);
        else
            chk(batt_ok && !batt_low, {"R8 ok verdict ", tag}, batt_ok, 1);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(ser_start && !ser_clk && !dio_oe && !busy && !batt_low && !batt_ok,
            "R1 reset state", {ser_start, ser_clk, dio_oe, busy, batt_low, batt_ok}, 6'b100000);
    endtask

    task automatic t_ok_first();
        run_check(7'h55, 0, 8'h80, 8'h00, 8'h00, 1, 1'b0, "boundary 128");
    endtask

    task automatic t_low_run();
        run_check(7'h2A, 5, 8'h7F, 8'h7F, 8'h00, 3, 1'b1, "three lows");
    endtask

    task automatic t_late_ok();
        run_check(7'h7F, 4, 8'h00, 8'h7F, 8'hC5, 3, 1'b0, "late good");
    endtask

    task automatic t_restart();
        run_check(7'h00, 0, 8'h7F, 8'h7F, 8'h80, 3, 1'b0, "R10 first");
        run_check(7'h13, 0, 8'h7F, 8'h01, 8'h7E, 3, 1'b1, "R10 second");
    endtask

    task automatic t_busy_go();
        rd_vals[0] = 8'hFF;
        for (int i = 1; i < 8; i++) rd_vals[i] = 8'hFF;
        rd_idx = 0; f_cnt = 0;
        chan_cfg = 7'h41;
        clk_div = 8'd3;
        pulse_go();
        repeat (60) @(negedge clk);
        pulse_go();
        wait_idle();
        chk(f_cnt == 4, "R2 go while busy ignored", f_cnt, 4);
        chk(batt_ok && !batt_low, "R8 ok after ignored go", batt_ok, 1);
        repeat (50) @(negedge clk);
        chk(!busy && f_cnt == 4, "R2 no second check", f_cnt, 4);
        chk(batt_ok && !batt_low, "R11 result holds", batt_ok, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ok_first();
        t_low_run();
        t_late_ok();
        t_restart();
        t_busy_go();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule